// File: doc/BRIEF.md
# Three-Bus Register Datapath with Fetch Sequencer

This block is a small processor core built around three buses. A register file with two read ports puts two source registers on buses A and B in the same cycle. The ALU combines them and drives its result onto bus C, and bus C feeds the register file's single write port. There are no holding registers between the buses and the ALU. The program counter has its own adder, so it advances while the ALU is busy routing the PC to the memory address register.

A four-step sequencer fetches and runs register-to-register instructions. In the first step the ALU passes the PC from bus B to the memory address register and raises a read request, while the incrementer adds 4 to the PC. In the second step the sequencer waits for the memory's function-complete strobe and captures the word in the data register. In the third step it copies the data register into the instruction register. In the fourth step one three-register operation reads, computes and writes back in a single cycle.

Memory is external: the block presents an address and a read request, and it expects data together with a one-cycle completion strobe.

Top module: `tribus_core`

## Requirements
- R1: While reset is held, the read request and the write-back strobe are low and the memory address is zero. After reset is released, the first fetch reads address 0.
- R2: In the address step the memory address register takes the PC as it was before the increment. That value is presented from the first cycle of the read request and held until the request ends.
- R3: Each fetch advances the PC by exactly 4, so successive fetches read addresses 0, 4, 8 and so on.
- R4: The read request stays high for as many cycles as the memory needs. It drops in the cycle after the completion strobe is accepted, and the data word is captured only on that strobe.
- R5: The write-back of a fetched instruction is visible exactly 2 cycles after the cycle in which the completion strobe is seen. The next read request rises exactly 4 cycles after that cycle.
- R6: The instruction word is laid out as rs2 in bits [2:0], rs1 in bits [5:3], rd in bits [8:6] and the opcode in bits [12:9]. Bits [31:13] have no effect.
- R7: Opcode 1 writes rs1 + rs2 and opcode 2 writes rs1 - rs2 into rd. Both wrap modulo 2^32.
- R8: Opcode 3 writes rs1 AND rs2, opcode 4 writes rs1 OR rs2, and opcode 5 writes rs1 XOR rs2.
- R9: Opcode 6 copies rs1 to rd (ALU pass A), and opcode 7 copies rs2 to rd (ALU pass B).
- R10: Opcode 8 writes rs1 + 4, taking the constant 4 from the bus B input select in place of a register.
- R11: If an instruction reads the same register it writes, it sees the value that register held before the instruction.
- R12: Opcode 0 and opcodes 9 to 15 write no register.
- R13: All eight 32-bit registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Memory address register contents |
| mem_rd | output | 1 | Read request, held until completion |
| mem_rdata | input | 32 | Read data from memory |
| mem_mfc | input | 1 | Memory function complete, one-cycle strobe |
| wb_en | output | 1 | Bus C is being written into the register file this cycle |
| wb_sel | output | 3 | Destination register of the write-back |
| wb_data | output | 32 | Value on bus C being written |

## Verification
Every result is tied to the cycle in which the bench's memory model raises the completion strobe. The write-back must appear exactly 2 cycles after that cycle, and the next read request exactly 4 cycles after it. The read address must equal four times the fetch count from the first request cycle onward.

A driver fills the program memory and pushes each expected write-back onto a queue. A monitor at the falling edge pops the queue on every write-back and compares register, value and cycle against it. Any write-back that arrives with the queue empty is reported as a failure, and this is how opcodes that must write nothing are caught. Memory latency is varied from 0 to 3 wait cycles across fetches, so the timing checks see several handshake lengths.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  localparam int INC_STEP = 4;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_MOVA = 4'd6;
  localparam logic [3:0] OP_MOVB = 4'd7;
  localparam logic [3:0] OP_ADD4 = 4'd8;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASSA, ALU_PASSB
  } alu_fn_e;

  typedef enum logic [1:0] {BSRC_REG, BSRC_PC, BSRC_K4} bsrc_e;

  typedef enum logic [1:0] {
    ST_ADDR, ST_WAIT, ST_LOAD_IR, ST_EXEC
  } step_e;

  typedef struct packed {
    alu_fn_e fn;
    bsrc_e   bsrc;
    logic    wr;
  } dec_s;

  function automatic dec_s decode_op(input logic [3:0] op);
    dec_s d;
    d.fn   = ALU_PASSB;
    d.bsrc = BSRC_REG;
    d.wr   = 1'b1;
    case (op)
      OP_ADD:  d.fn = ALU_ADD;
      OP_SUB:  d.fn = ALU_SUB;
      OP_AND:  d.fn = ALU_AND;
      OP_OR:   d.fn = ALU_OR;
      OP_XOR:  d.fn = ALU_XOR;
      OP_MOVA: d.fn = ALU_PASSA;
      OP_MOVB: d.fn = ALU_PASSB;
      OP_ADD4: begin d.fn = ALU_ADD; d.bsrc = BSRC_K4; end
      default: d.wr = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  logic [DW-1:0]   regs [NREG];
  logic [NREG-1:0] wsel;

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wsel[g] = we && (wa == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wsel[i]) regs[i] <= wd;
    end
  end

  // reads see the array before this cycle's write (old value)
  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  p_write_commits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(wa)] == $past(wd));

  p_one_write_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] bus_a,
  input  logic [DW-1:0] bus_b,
  output logic [DW-1:0] bus_c
);

  function automatic logic [DW-1:0] alu_calc(input alu_fn_e f,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (f)
      ALU_ADD:   return a + b;
      ALU_SUB:   return a - b;
      ALU_AND:   return a & b;
      ALU_OR:    return a | b;
      ALU_XOR:   return a ^ b;
      ALU_PASSA: return a;
      default:   return b;
    endcase
  endfunction

  assign bus_c = alu_calc(fn, bus_a, bus_b);

endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
#(
  parameter int DW   = 32,
  parameter int RIDX = 3,
  localparam int OPL = 3 * RIDX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   bus_c,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_mfc,
  output logic [DW-1:0]   pc,
  output logic [DW-1:0]   mar,
  output logic            rd_req,
  output logic [RIDX-1:0] sel_a,
  output logic [RIDX-1:0] sel_b,
  output logic [RIDX-1:0] sel_d,
  output alu_fn_e         fn,
  output bsrc_e           bsrc,
  output logic            rf_we
);

  step_e         step_q;
  logic [DW-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic          req_q;
  logic [3:0]    opcode;
  dec_s          dec;
  logic          in_addr, in_exec, mfc_take;

  function automatic logic [DW-1:0] pc_next(input logic [DW-1:0] v);
    return v + DW'(INC_STEP);
  endfunction

  assign opcode   = ir_q[OPL+3:OPL];
  assign dec      = decode_op(opcode);
  assign in_addr  = (step_q == ST_ADDR);
  assign in_exec  = (step_q == ST_EXEC);
  assign mfc_take = (step_q == ST_WAIT) && mem_mfc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_ADDR;
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      req_q  <= 1'b0;
    end else begin
      case (step_q)
        ST_ADDR: begin
          mar_q  <= bus_c;
          pc_q   <= pc_next(pc_q);
          req_q  <= 1'b1;
          step_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mfc_take) begin
            mdr_q  <= mem_rdata;
            req_q  <= 1'b0;
            step_q <= ST_LOAD_IR;
          end
        end
        ST_LOAD_IR: begin
          ir_q   <= mdr_q;
          step_q <= ST_EXEC;
        end
        default: step_q <= ST_ADDR;
      endcase
    end
  end

  always_comb begin
    fn    = ALU_PASSB;
    bsrc  = BSRC_REG;
    rf_we = 1'b0;
    if (in_addr) begin
      bsrc = BSRC_PC;
    end else if (in_exec) begin
      fn    = dec.fn;
      bsrc  = dec.bsrc;
      rf_we = dec.wr;
    end
  end

  assign pc     = pc_q;
  assign mar    = mar_q;
  assign rd_req = req_q;
  assign sel_b  = ir_q[RIDX-1:0];
  assign sel_a  = ir_q[2*RIDX-1:RIDX];
  assign sel_d  = ir_q[3*RIDX-1:2*RIDX];

  p_mar_old_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> (mar_q == pc_q - DW'(INC_STEP)));

  p_pc_by_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_q) |-> (pc_q == $past(pc_q) + DW'(INC_STEP)));

  p_req_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && mem_mfc) |=> !req_q);

  p_mdr_on_mfc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdr_q) |-> $past(mem_mfc));

  p_ir_from_mdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_exec |-> (ir_q == mdr_q));

endmodule

// File: rtl/tribus_core.sv
module tribus_core
  import tribus_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [DW-1:0]   mem_addr,
  output logic            mem_rd,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_mfc,
  output logic            wb_en,
  output logic [RIDX-1:0] wb_sel,
  output logic [DW-1:0]   wb_data
);

  logic [DW-1:0]   bus_a, bus_b, bus_c, rf_b, pc;
  logic [RIDX-1:0] sel_a, sel_b, sel_d;
  alu_fn_e         fn;
  bsrc_e           bsrc;
  logic            rf_we;

  tribus_ctrl #(.DW(DW), .RIDX(RIDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_c(bus_c), .mem_rdata(mem_rdata),
    .mem_mfc(mem_mfc), .pc(pc), .mar(mem_addr), .rd_req(mem_rd),
    .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d), .fn(fn), .bsrc(bsrc),
    .rf_we(rf_we)
  );

  tribus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra_a(sel_a), .ra_b(sel_b),
    .rd_a(bus_a), .rd_b(rf_b), .we(rf_we), .wa(sel_d), .wd(bus_c)
  );

  always_comb begin
    case (bsrc)
      BSRC_PC: bus_b = pc;
      BSRC_K4: bus_b = DW'(INC_STEP);
      default: bus_b = rf_b;
    endcase
  end

  tribus_alu #(.DW(DW)) u_alu (
    .fn(fn), .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c)
  );

  assign wb_en   = rf_we;
  assign wb_sel  = sel_d;
  assign wb_data = bus_c;

  p_no_wb_during_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !wb_en);

endmodule

// File: tb/tribus_core_test.sv
module tribus_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic [31:0] mem_rdata = '0;
  logic        mem_mfc = 1'b0;
  logic        wb_en;
  logic [2:0]  wb_sel;
  logic [31:0] wb_data;

  always #2 clk = ~clk;

  tribus_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_data(wb_data)
  );

  typedef struct {
    logic [2:0]  sel;
    logic [31:0] val;
    string       tag;
  } wb_item_t;

  wb_item_t    exp_q[$];
  logic [31:0] prog [64];
  logic [31:0] mdl  [8];
  int          prog_n = 0;
  int          vectors = 0;
  int          miscompares = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: places one instruction and queues its expected write-back
  task automatic issue(input logic [3:0] op, input int rd, input int ra,
                       input int rb, input logic [18:0] junk, input string tag);
    logic [31:0] a, b, r;
    bit wr;
    a = mdl[ra];
    b = mdl[rb];
    wr = 1;
    r = '0;
    case (op)
      4'd1: r = a + b;
      4'd2: r = a + (~b) + 32'd1;
      4'd3: r = ~(~a | ~b);
      4'd4: r = ~(~a & ~b);
      4'd5: r = (a | b) & ~(a & b);
      4'd6: r = a;
      4'd7: r = b;
      4'd8: r = a + 32'd4;
      default: wr = 0;
    endcase
    prog[prog_n] = {junk, op, 3'(rd), 3'(ra), 3'(rb)};
    prog_n++;
    if (wr) begin
      exp_q.push_back('{sel: 3'(rd), val: r, tag: tag});
      mdl[rd] = r;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = '0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    issue(4'd1, 7, 6, 5, 19'h0, "R13");
    issue(4'd8, 1, 0, 0, 19'h0, "R10");
    issue(4'd8, 2, 1, 3, 19'h0, "R10");
    issue(4'd1, 3, 1, 2, 19'h0, "R7");
    issue(4'd2, 4, 1, 2, 19'h0, "R7");
    issue(4'd1, 1, 1, 1, 19'h0, "R11");
    issue(4'd5, 5, 3, 4, 19'h0, "R8");
    issue(4'd3, 6, 3, 4, 19'h0, "R8");
    issue(4'd4, 7, 5, 2, 19'h0, "R8");
    issue(4'd6, 0, 4, 2, 19'h0, "R9");
    issue(4'd7, 2, 0, 7, 19'h0, "R9");
    issue(4'd8, 5, 5, 5, 19'h5A5A5, "R6");
    issue(4'd0, 3, 1, 2, 19'h0, "R12");
    issue(4'd9, 3, 1, 2, 19'h0, "R12");
    issue(4'd15, 1, 4, 4, 19'h7FFFF, "R12");
    issue(4'd6, 6, 3, 0, 19'h0, "R12");
    issue(4'd6, 6, 1, 0, 19'h0, "R12");
    issue(4'd2, 4, 4, 4, 19'h0, "R11");
    issue(4'd2, 3, 0, 3, 19'h12345, "R6");
    issue(4'd1, 0, 0, 0, 19'h0, "R11");
    issue(4'd5, 7, 7, 0, 19'h0, "R8");
    issue(4'd7, 1, 2, 7, 19'h0, "R9");
  end

  // reset state, then release
  initial begin
    repeat (3) @(negedge clk);
    check(mem_rd == 1'b0, "R1", "read request in reset", 32'(mem_rd), 32'd0);
    check(wb_en == 1'b0, "R1", "write-back in reset", 32'(wb_en), 32'd0);
    check(mem_addr == 32'd0, "R1", "address in reset", mem_addr, 32'd0);
    rst_n = 1'b1;
  end

  // monitor and memory model, all at the falling edge
  initial begin
    int  cyc = 0, fetch_n = 0, cur_lat = 0, wait_cnt = 0, last_mfc = 0;
    bit  have_mfc = 0, rd_prev = 0;
    logic [31:0] cur_addr = '0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (wb_en) begin
        if (exp_q.size() == 0) begin
          check(0, "R12", "write-back with nothing expected", 32'(wb_sel), 32'hFFFFFFFF);
        end else begin
          wb_item_t e;
          e = exp_q.pop_front();
          check(wb_sel == e.sel, e.tag, "destination", 32'(wb_sel), 32'(e.sel));
          check(wb_data == e.val, e.tag, "result", wb_data, e.val);
          check(cyc == last_mfc + 2, "R5", "write-back cycle", 32'(cyc), 32'(last_mfc + 2));
        end
      end
      if (mem_rd && !rd_prev) begin
        cur_addr = 32'(fetch_n * 4);
        check(mem_addr == cur_addr, fetch_n == 0 ? "R1" : "R3", "fetch address",
              mem_addr, cur_addr);
        if (have_mfc)
          check(cyc == last_mfc + 4, "R5", "next read cycle", 32'(cyc), 32'(last_mfc + 4));
        cur_lat = fetch_n % 4;
        wait_cnt = 0;
        fetch_n++;
      end else if (mem_rd) begin
        check(mem_addr == cur_addr, "R2", "address held", mem_addr, cur_addr);
      end
      rd_prev = mem_rd;
      if (mem_mfc) begin
        mem_mfc = 1'b0;
        check(mem_rd == 1'b0, "R4", "request after completion", 32'(mem_rd), 32'd0);
      end else if (mem_rd) begin
        if (wait_cnt == cur_lat) begin
          mem_rdata = (mem_addr < 32'd256) ? prog[mem_addr[7:2]] : 32'd0;
          mem_mfc   = 1'b1;
          last_mfc  = cyc;
          have_mfc  = 1;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // end of run: drain the scoreboard, then watch for stray write-backs
  initial begin
    wait (rst_n);
    repeat (5) @(negedge clk);
    wait (exp_q.size() == 0);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R12", "queue empty at end", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R5", "watchdog, pending write-backs", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule